// File: doc/BRIEF.md
# Threshold-Triggered Rank Sparing Engine

This block retires a failing memory rank without software help. It keeps an error count for each rank. When a rank's count reaches a programmed threshold, it raises an interrupt and copies that rank, location by location, onto a spare rank that was chosen at configuration time. The system keeps running during the copy. Reads are served by the failing rank. Writes to the failing rank are also sent to the spare, so the spare never falls behind.

When the last location has been copied, the engine rewrites the address-decode table. Every entry that named the failing rank now names the spare, and every limit field keeps its value. From then on, requests aimed at the failing rank are steered to the spare. Only one sparing event is supported. Later threshold crossings still raise the interrupt but start no copy.

The block sits between the request path and the memory command queue. It steers each system request to a target rank, and it issues its own copy reads and writes on a command port with a valid/ready handshake.

Top module: `rank_spare_engine`

## Requirements
- R1: While `cfg_enable` is low, error events are ignored and leave every rank's error count unchanged.
- R2: An enabled error event that brings its rank's count to exactly `cfg_threshold` (a threshold of 0 never fires) raises `irq` for one cycle in the next cycle. If the engine has never spared and the rank is not the spare rank, the copy also starts in that cycle and `sts_busy` goes high.
- R3: The copy visits addresses 0 to the last address in ascending order. For each address it issues a read (`mem_cmd_write`=0) to the failing rank and waits for `mem_rd_valid`. It then issues a write (`mem_cmd_write`=1) of the returned data to the same address on the spare rank. A command is held unchanged until `mem_cmd_ready` is high.
- R4: While `sts_busy` is high, a system read to the failing rank targets the failing rank, and `sys_dup_valid` stays 0.
- R5: While `sts_busy` is high, a system write to the failing rank targets the failing rank and also raises `sys_dup_valid`, with `sys_dup_rank` equal to the spare rank. Writes to other ranks are not duplicated.
- R6: A system write to the failing rank at the address being copied, at any time from that address's read command until its write is accepted, cancels the copy write for that address.
- R7: After the last copy write, every decode entry whose rank field equals the failing rank is set to the spare rank. Limit fields and all other entries are unchanged. Then `sts_busy` falls and `sts_done` rises.
- R8: Once `sts_done` is high, requests to the failing rank have `sys_tgt_rank` equal to the spare rank, and requests to other ranks keep their own rank.
- R9: Once `sts_done` is high it stays high. Further threshold crossings raise `irq` but issue no copy command.
- R10: A decode-table write (`dec_wr_en`) sets the indexed entry's rank and limit, and `dec_rd_idx` reads any entry back combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Arms error counting and sparing |
| cfg_spare_rank | input | RANK_W | Rank reserved as the spare |
| cfg_threshold | input | CNT_W | Error count that triggers sparing |
| err_valid | input | 1 | Error event strobe |
| err_rank | input | RANK_W | Rank that produced the error |
| mem_cmd_valid | output | 1 | Copy command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = copy write, 0 = copy read |
| mem_cmd_rank | output | RANK_W | Command rank |
| mem_cmd_addr | output | ADDR_W | Location within the rank |
| mem_cmd_wdata | output | DATA_W | Copy write data |
| mem_rd_valid | input | 1 | Read data return strobe |
| mem_rd_data | input | DATA_W | Read data |
| sys_req_valid | input | 1 | System request valid |
| sys_req_write | input | 1 | System request is a write |
| sys_req_rank | input | RANK_W | Rank decoded for the request |
| sys_req_addr | input | ADDR_W | Location of the request |
| sys_tgt_rank | output | RANK_W | Rank the request must use |
| sys_dup_valid | output | 1 | Write must also go to `sys_dup_rank` |
| sys_dup_rank | output | RANK_W | Duplicate write rank |
| irq | output | 1 | Threshold-crossing interrupt pulse |
| dec_wr_en | input | 1 | Decode entry write strobe |
| dec_wr_idx | input | DEC_IDX_W | Entry to write |
| dec_wr_rank | input | RANK_W | Rank field to write |
| dec_wr_limit | input | LIMIT_W | Limit field to write |
| dec_rd_idx | input | DEC_IDX_W | Entry to read |
| dec_rd_rank | output | RANK_W | Rank field of the read entry |
| dec_rd_limit | output | LIMIT_W | Limit field of the read entry |
| sts_busy | output | 1 | Copy or remap in progress |
| sts_done | output | 1 | Spare has replaced the failing rank |

## Verification
The copy is run against a memory model whose ready signal drops every third cycle and whose read data returns two cycles late. This separates correct command holding and data capture from a design that only works with an ideal memory. During the copy, three system requests are applied: a write to a location that has not been copied yet, a read, and a write that lands on the location whose read is in flight. The first shows whether duplicated data later survives the copy. The third shows whether a stale copy write is cancelled. Error streams are applied while the engine is disabled, below the threshold, at the threshold and after sparing. These tell gating, exact-count triggering and the one-shot rule apart. The decode table is checked before and after remapping, with entries that name the failing rank, another rank and the spare.

// File: rtl/rse_pkg.sv
package rse_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_REQ  = 3'd1,
      ST_RD_WAIT = 3'd2,
      ST_WR_REQ  = 3'd3,
      ST_REMAP   = 3'd4,
      ST_DONE    = 3'd5
   } rse_state_e;

   function automatic logic is_copy_phase(input rse_state_e s);
      return (s == ST_RD_REQ) || (s == ST_RD_WAIT) || (s == ST_WR_REQ);
   endfunction
endpackage

// File: rtl/rse_err_counters.sv
module rse_err_counters #(
   parameter int NUM_RANKS = 4,
   parameter int RANK_W    = 2,
   parameter int CNT_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CNT_W-1:0]  threshold,
   input  logic              err_valid,
   input  logic [RANK_W-1:0] err_rank,
   output logic              hit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [NUM_RANKS-1:0] hit_vec;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("rse_err_counters: CNT_W must be at least 1");
      end
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
         logic             sel;
         logic [CNT_W-1:0] cnt_q;

         assign sel = err_valid && enable && (err_rank == RANK_W'(r));

         always_ff @(posedge clk) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (sel && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end

         assign hit_vec[r] = sel && (cnt_q != CNT_MAX) &&
                             ((cnt_q + 1'b1) == threshold);

         assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |=> $stable(cnt_q));
      end
   endgenerate

   assign hit = |hit_vec;
endmodule

// File: rtl/rse_copy_fsm.sv
module rse_copy_fsm
   import rse_pkg::*;
#(
   parameter int RANK_W = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RANK_W-1:0] start_rank,
   input  logic [RANK_W-1:0] spare_rank,
   input  logic              sys_wr_fail,
   input  logic [ADDR_W-1:0] sys_wr_addr,
   output logic              mem_cmd_valid,
   input  logic              mem_cmd_ready,
   output logic              mem_cmd_write,
   output logic [RANK_W-1:0] mem_cmd_rank,
   output logic [ADDR_W-1:0] mem_cmd_addr,
   output logic [DATA_W-1:0] mem_cmd_wdata,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output rse_state_e        state,
   output logic [RANK_W-1:0] fail_rank,
   output logic [RANK_W-1:0] spare_used
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   rse_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [RANK_W-1:0] fail_q, spare_q;
   logic              skip_q;
   logic              collide;
   logic              advance;

   assign collide = sys_wr_fail && (sys_wr_addr == addr_q) && is_copy_phase(state_q);
   assign advance = (state_q == ST_WR_REQ) && (skip_q || collide || mem_cmd_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         fail_q  <= '0;
         spare_q <= '0;
         skip_q  <= 1'b0;
      end else begin
         if (collide) skip_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: if (start) begin
               fail_q  <= start_rank;
               spare_q <= spare_rank;
               addr_q  <= '0;
               skip_q  <= 1'b0;
               state_q <= ST_RD_REQ;
            end
            ST_RD_REQ:  if (mem_cmd_ready) state_q <= ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rd_valid) begin
               data_q  <= mem_rd_data;
               state_q <= ST_WR_REQ;
            end
            ST_WR_REQ: if (advance) begin
               skip_q <= 1'b0;
               if (addr_q == LAST_ADDR) state_q <= ST_REMAP;
               else begin
                  addr_q  <= addr_q + 1'b1;
                  state_q <= ST_RD_REQ;
               end
            end
            ST_REMAP: state_q <= ST_DONE;
            ST_DONE:  state_q <= ST_DONE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_cmd_valid = (state_q == ST_RD_REQ) ||
                          ((state_q == ST_WR_REQ) && !skip_q && !collide);
   assign mem_cmd_write = (state_q == ST_WR_REQ);
   assign mem_cmd_rank  = (state_q == ST_WR_REQ) ? spare_q : fail_q;
   assign mem_cmd_addr  = addr_q;
   assign mem_cmd_wdata = data_q;
   assign state         = state_q;
   assign fail_rank     = fail_q;
   assign spare_used    = spare_q;

   assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !mem_cmd_write && !mem_cmd_ready) |=>
      (mem_cmd_valid && !mem_cmd_write && $stable(mem_cmd_addr)));
endmodule

// File: rtl/rse_remap_table.sv
module rse_remap_table #(
   parameter int NUM_DEC   = 4,
   parameter int IDX_W     = 2,
   parameter int RANK_W    = 2,
   parameter int LIMIT_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [RANK_W-1:0]  wr_rank,
   input  logic [LIMIT_W-1:0] wr_limit,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [RANK_W-1:0]  rd_rank,
   output logic [LIMIT_W-1:0] rd_limit,
   input  logic               remap,
   input  logic [RANK_W-1:0]  from_rank,
   input  logic [RANK_W-1:0]  to_rank
);
   logic [RANK_W-1:0]  rank_arr  [NUM_DEC];
   logic [LIMIT_W-1:0] limit_arr [NUM_DEC];

   generate
      if (NUM_DEC < 2) begin : g_bad_dec
         $error("rse_remap_table: NUM_DEC must be at least 2");
      end
      for (genvar e = 0; e < NUM_DEC; e++) begin : g_entry
         logic sw_hit;
         assign sw_hit = wr_en && (wr_idx == IDX_W'(e));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rank_arr[e]  <= '0;
               limit_arr[e] <= '0;
            end else if (sw_hit) begin
               rank_arr[e]  <= wr_rank;
               limit_arr[e] <= wr_limit;
            end else if (remap && rank_arr[e] == from_rank) begin
               rank_arr[e]  <= to_rank;
            end
         end

         assert_limit_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (remap && !sw_hit) |=> $stable(limit_arr[e]));
      end
   endgenerate

   assign rd_rank  = rank_arr[rd_idx];
   assign rd_limit = limit_arr[rd_idx];
endmodule

// File: rtl/rank_spare_engine.sv
module rank_spare_engine
   import rse_pkg::*;
#(
   parameter int NUM_RANKS = 4,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 16,
   parameter int CNT_W     = 4,
   parameter int NUM_DEC   = 4,
   parameter int LIMIT_W   = 8,
   localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int DEC_IDX_W = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_enable,
   input  logic [RANK_W-1:0]    cfg_spare_rank,
   input  logic [CNT_W-1:0]     cfg_threshold,
   input  logic                 err_valid,
   input  logic [RANK_W-1:0]    err_rank,
   output logic                 mem_cmd_valid,
   input  logic                 mem_cmd_ready,
   output logic                 mem_cmd_write,
   output logic [RANK_W-1:0]    mem_cmd_rank,
   output logic [ADDR_W-1:0]    mem_cmd_addr,
   output logic [DATA_W-1:0]    mem_cmd_wdata,
   input  logic                 mem_rd_valid,
   input  logic [DATA_W-1:0]    mem_rd_data,
   input  logic                 sys_req_valid,
   input  logic                 sys_req_write,
   input  logic [RANK_W-1:0]    sys_req_rank,
   input  logic [ADDR_W-1:0]    sys_req_addr,
   output logic [RANK_W-1:0]    sys_tgt_rank,
   output logic                 sys_dup_valid,
   output logic [RANK_W-1:0]    sys_dup_rank,
   output logic                 irq,
   input  logic                 dec_wr_en,
   input  logic [DEC_IDX_W-1:0] dec_wr_idx,
   input  logic [RANK_W-1:0]    dec_wr_rank,
   input  logic [LIMIT_W-1:0]   dec_wr_limit,
   input  logic [DEC_IDX_W-1:0] dec_rd_idx,
   output logic [RANK_W-1:0]    dec_rd_rank,
   output logic [LIMIT_W-1:0]   dec_rd_limit,
   output logic                 sts_busy,
   output logic                 sts_done
);
   generate
      if (NUM_RANKS < 2) begin : g_bad_ranks
         $error("rank_spare_engine: NUM_RANKS must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_widths
         $error("rank_spare_engine: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic              thr_hit;
   logic              start;
   logic              irq_q;
   rse_state_e        state;
   logic [RANK_W-1:0] fail_rank;
   logic [RANK_W-1:0] spare_used;
   logic              req_fail;
   logic              sys_wr_fail;

   rse_err_counters #(
      .NUM_RANKS (NUM_RANKS),
      .RANK_W    (RANK_W),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (cfg_enable),
      .threshold (cfg_threshold),
      .err_valid (err_valid),
      .err_rank  (err_rank),
      .hit       (thr_hit)
   );

   assign start = thr_hit && (state == ST_IDLE) && (err_rank != cfg_spare_rank);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= thr_hit;
   end
   assign irq = irq_q;

   assign req_fail    = sys_req_valid && (sys_req_rank == fail_rank);
   assign sys_wr_fail = req_fail && sys_req_write && sts_busy;

   rse_copy_fsm #(
      .RANK_W (RANK_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .start_rank    (err_rank),
      .spare_rank    (cfg_spare_rank),
      .sys_wr_fail   (sys_wr_fail),
      .sys_wr_addr   (sys_req_addr),
      .mem_cmd_valid (mem_cmd_valid),
      .mem_cmd_ready (mem_cmd_ready),
      .mem_cmd_write (mem_cmd_write),
      .mem_cmd_rank  (mem_cmd_rank),
      .mem_cmd_addr  (mem_cmd_addr),
      .mem_cmd_wdata (mem_cmd_wdata),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_data   (mem_rd_data),
      .state         (state),
      .fail_rank     (fail_rank),
      .spare_used    (spare_used)
   );

   rse_remap_table #(
      .NUM_DEC (NUM_DEC),
      .IDX_W   (DEC_IDX_W),
      .RANK_W  (RANK_W),
      .LIMIT_W (LIMIT_W)
   ) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (dec_wr_en),
      .wr_idx    (dec_wr_idx),
      .wr_rank   (dec_wr_rank),
      .wr_limit  (dec_wr_limit),
      .rd_idx    (dec_rd_idx),
      .rd_rank   (dec_rd_rank),
      .rd_limit  (dec_rd_limit),
      .remap     (state == ST_REMAP),
      .from_rank (fail_rank),
      .to_rank   (spare_used)
   );

   assign sts_busy      = is_copy_phase(state) || (state == ST_REMAP);
   assign sts_done      = (state == ST_DONE);
   assign sys_tgt_rank  = (sts_done && sys_req_rank == fail_rank) ? spare_used : sys_req_rank;
   assign sys_dup_valid = sys_wr_fail;
   assign sys_dup_rank  = spare_used;

   assert_busy_with_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_busy) |-> irq);
   assert_dup_other_rank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_dup_valid |-> (sys_dup_rank != sys_tgt_rank));
   assert_collide_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_dup_valid && mem_cmd_write && sys_req_addr == mem_cmd_addr) |-> !mem_cmd_valid);
   assert_end_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_busy) |-> sts_done);
   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sts_done |=> (sts_done && !sts_busy && !mem_cmd_valid));
endmodule

// File: tb/rank_spare_engine_tb.sv
module rank_spare_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 2, AW = 4, DW = 16, CW = 4, IW = 2, LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 1'b0;
   logic [RW-1:0] cfg_spare_rank = '0;
   logic [CW-1:0] cfg_threshold = '0;
   logic          err_valid = 1'b0;
   logic [RW-1:0] err_rank = '0;
   logic          mem_cmd_valid, mem_cmd_write;
   logic          mem_cmd_ready;
   logic [RW-1:0] mem_cmd_rank;
   logic [AW-1:0] mem_cmd_addr;
   logic [DW-1:0] mem_cmd_wdata;
   logic          mem_rd_valid;
   logic [DW-1:0] mem_rd_data;
   logic          sys_req_valid = 1'b0, sys_req_write = 1'b0;
   logic [RW-1:0] sys_req_rank = '0;
   logic [AW-1:0] sys_req_addr = '0;
   logic [DW-1:0] sys_wdata = '0;
   logic [RW-1:0] sys_tgt_rank, sys_dup_rank;
   logic          sys_dup_valid, irq;
   logic          dec_wr_en = 1'b0;
   logic [IW-1:0] dec_wr_idx = '0, dec_rd_idx = '0;
   logic [RW-1:0] dec_wr_rank = '0, dec_rd_rank;
   logic [LW-1:0] dec_wr_limit = '0, dec_rd_limit;
   logic          sts_busy, sts_done;

   rank_spare_engine #(.NUM_RANKS(4), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW),
                       .NUM_DEC(4), .LIMIT_W(LW)) u_dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   bit seen_rd5 = 0;
   int rd_rank_errs = 0;
   logic [RW+AW+DW-1:0] exp_q[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int r, input int a);
      return 16'hA000 | DW'(r << 8) | DW'(a);
   endfunction

   // memory model and scoreboard monitor
   logic [DW-1:0] mem_m [4][16];
   logic          p1_v;
   logic [DW-1:0] p1_d;
   int            rdy_cnt;
   assign mem_cmd_ready = (rdy_cnt != 2);

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < 4; r++)
            for (int a = 0; a < 16; a++) mem_m[r][a] <= pat(r, a);
         p1_v <= 0; p1_d <= '0; mem_rd_valid <= 0; mem_rd_data <= '0; rdy_cnt <= 0;
      end else begin
         rdy_cnt      <= (rdy_cnt == 2) ? 0 : rdy_cnt + 1;
         mem_rd_valid <= p1_v;
         mem_rd_data  <= p1_d;
         p1_v         <= 0;
         if (mem_cmd_valid && mem_cmd_ready && !mem_cmd_write) begin
            p1_v <= 1;
            p1_d <= mem_m[mem_cmd_rank][mem_cmd_addr];
            if (mem_cmd_addr == 5) seen_rd5 <= 1;
            if (mem_cmd_rank != 1) rd_rank_errs++;
         end
         if (mem_cmd_valid && mem_cmd_ready && mem_cmd_write) begin
            mem_m[mem_cmd_rank][mem_cmd_addr] <= mem_cmd_wdata;
            if (exp_q.size() == 0) check("R3 unexpected copy write", 1, 0);
            else check("R3/R6 copy write rank/addr/data",
                       {mem_cmd_rank, mem_cmd_addr, mem_cmd_wdata}, exp_q.pop_front());
         end
         if (sys_req_valid && sys_req_write) begin
            mem_m[sys_tgt_rank][sys_req_addr] <= sys_wdata;
            if (sys_dup_valid) mem_m[sys_dup_rank][sys_req_addr] <= sys_wdata;
         end
      end
   end

   task automatic err_pulse(input logic [RW-1:0] r);
      err_valid = 1; err_rank = r;
      @(negedge clk);
      err_valid = 0;
   endtask

   task automatic dec_write(input int i, input int r, input int l);
      dec_wr_en = 1; dec_wr_idx = IW'(i); dec_wr_rank = RW'(r); dec_wr_limit = LW'(l);
      @(negedge clk);
      dec_wr_en = 0;
   endtask

   task automatic dec_check(input string req, input int i, input int r, input int l);
      dec_rd_idx = IW'(i);
      #1;
      check(req, {dec_rd_rank, dec_rd_limit}, {RW'(r), LW'(l)});
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("reset busy/done/irq/cmd", {sts_busy, sts_done, irq, mem_cmd_valid}, 0);
      dec_check("R10 reset entry", 0, 0, 0);

      dec_write(0, 1, 10); dec_write(1, 2, 20); dec_write(2, 1, 30); dec_write(3, 3, 40);
      dec_check("R10 entry0", 0, 1, 10);
      dec_check("R10 entry3", 3, 3, 40);

      cfg_spare_rank = 3; cfg_threshold = 3;
      // R1: disabled errors not counted
      err_pulse(2); err_pulse(2);
      cfg_enable = 1;
      err_pulse(2);
      check("R1 disabled events ignored (no irq)", {irq, sts_busy}, 0);

      err_pulse(1);
      check("R2 below threshold", {irq, sts_busy}, 0);
      err_pulse(1);
      check("R2 below threshold", {irq, sts_busy}, 0);

      for (int a = 0; a < 16; a++)
         if (a != 5) exp_q.push_back({2'd3, AW'(a), (a == 12) ? 16'hC0DE : pat(1, a)});

      err_pulse(1);
      check("R2 irq and start", {irq, sts_busy}, 2'b11);

      // R5: write ahead of the copy pointer
      sys_req_valid = 1; sys_req_write = 1; sys_req_rank = 1; sys_req_addr = 12;
      sys_wdata = 16'hC0DE;
      #1;
      check("R5 write dup", {sys_tgt_rank, sys_dup_valid, sys_dup_rank}, {2'd1, 1'b1, 2'd3});
      @(negedge clk);
      check("R2 irq single pulse", irq, 0);
      // R4: read during copy
      sys_req_write = 0; sys_req_addr = 3;
      #1;
      check("R4 read to failing rank", {sys_tgt_rank, sys_dup_valid}, {2'd1, 1'b0});
      @(negedge clk);
      // R5: write to other rank not duplicated
      sys_req_write = 1; sys_req_rank = 2; sys_req_addr = 7; sys_wdata = 16'h7777;
      #1;
      check("R5 other rank no dup", {sys_tgt_rank, sys_dup_valid}, {2'd2, 1'b0});
      @(negedge clk);
      sys_req_valid = 0; sys_req_write = 0;

      // R6: collide with address 5 during its read
      wait (seen_rd5);
      @(negedge clk);
      sys_req_valid = 1; sys_req_write = 1; sys_req_rank = 1; sys_req_addr = 5;
      sys_wdata = 16'h5555;
      @(negedge clk);
      sys_req_valid = 0; sys_req_write = 0;

      while (!sts_done) @(negedge clk);
      check("R7 busy low at done", sts_busy, 0);
      check("R3 all copy writes seen", exp_q.size(), 0);
      check("R3 reads only to failing rank", rd_rank_errs, 0);
      check("R6 spare keeps system data", mem_m[3][5], 16'h5555);
      check("R5 spare got dup data", mem_m[3][12], 16'hC0DE);
      check("R3 spare copied", mem_m[3][9], pat(1, 9));
      dec_check("R7 entry0 remapped", 0, 3, 10);
      dec_check("R7 entry1 untouched", 1, 2, 20);
      dec_check("R7 entry2 remapped", 2, 3, 30);
      dec_check("R7 entry3 untouched", 3, 3, 40);

      sys_req_valid = 1; sys_req_rank = 1; sys_req_addr = 2;
      #1;
      check("R8 failing rank steered to spare", {sys_tgt_rank, sys_dup_valid}, {2'd3, 1'b0});
      sys_req_rank = 2;
      #1;
      check("R8 other rank kept", sys_tgt_rank, 2);
      @(negedge clk);
      sys_req_valid = 0;

      err_pulse(2);
      check("R9 below threshold", irq, 0);
      err_pulse(2);
      check("R9 irq after sparing", {irq, sts_done, sts_busy}, 3'b110);
      for (int k = 0; k < 4; k++) begin
         check("R9 no new copy command", {mem_cmd_valid, sts_busy, sts_done}, 3'b001);
         @(negedge clk);
      end
      summary();
   end
endmodule